// File: doc/BRIEF.md
# Pseudo-Associative Serial-Probe Cache

This block is a read cache whose storage is a single direct-mapped array of `LINES` entries. It behaves like a `WAYS`-way set-associative cache with `LINES/WAYS` sets. Tags are not compared across all ways at once. Instead, the controller reads the same array once per cycle, trying the ways in turn. For each probe, the array index is the way number placed above the low set-index bits of the request address.

A processor request is accepted when the block is idle. The block answers with a single response pulse. That response carries the data, a hit flag, the way that supplied the line and the number of probes used. When every probe misses, the block asks the next level for the line through the refill port. It then writes the returned line into the chosen slot and forwards the same data to the processor.

Top module: `pseudo_assoc_cache`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `fill_req_valid` are 0, and every line is invalid, so the first access to any address misses.
- R2: The probe for way `w` reads array line `{w, addr[SET_W-1:0]}`, where the set index is the low `log2(LINES/WAYS)` address bits. Ways are probed in order 0, 1, ..., `WAYS-1`, and a line filled into way `w` is later found on probe `w`.
- R3: A hit on probe `w` produces `rsp_valid` exactly `w+1` cycles after the accepting clock edge, with `rsp_hit`=1, `rsp_way`=`w`, `rsp_probes`=`w+1` and the stored data.
- R4: When all probes miss, `fill_req_valid` rises `WAYS` cycles after acceptance with `fill_req_addr` equal to the request address. It stays high until `fill_rsp_valid` is seen.
- R5: A refilled line is placed in the lowest-numbered probed way whose slot was invalid. If all slots were valid, it goes into way 0.
- R6: The cycle after `fill_rsp_valid` is sampled during a refill, `rsp_valid` is 1 with `rsp_data` equal to the returned data, `rsp_hit`=0, `rsp_probes`=`WAYS` and `rsp_way` equal to the slot chosen by R5.
- R7: `req_ready` is 0 from the accepting edge until the response cycle. A request held on `req_valid` in that time produces no response or refill of its own.
- R8: The stored tag is every address bit above the set index. Two addresses with the same set index but different upper bits never hit on each other's line.
- R9: `fill_rsp_valid` while no refill is pending changes no stored line.
- R10: `rsp_valid` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor read request |
| req_addr | input | ADDR_W | Request address |
| req_ready | output | 1 | Block is idle and takes a request this cycle |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | DATA_W | Returned line |
| rsp_hit | output | 1 | 1 when a probe matched, 0 after a refill |
| rsp_way | output | log2(WAYS) | Way that hit or received the refill |
| rsp_probes | output | log2(WAYS)+1 | Number of probes performed |
| fill_req_valid | output | 1 | Refill request to the next level |
| fill_req_addr | output | ADDR_W | Address to refill |
| fill_rsp_valid | input | 1 | Refill data is present |
| fill_rsp_data | input | DATA_W | Refill data |

## Verification
The embedded properties check on every cycle that:
- the response is a single-cycle pulse;
- the probe count agrees with the reported way on hits and equals `WAYS` on refills;
- the block drops `req_ready` right after accepting a request;
- a refill request is held until it is answered;
- an array write leaves the addressed slot valid.

Only the bench's scenarios can show that a line is actually found again in the right way at the right latency. The same goes for the victim choice between invalid and fully occupied sets, for the exactness of the tag across aliasing addresses, and for stray refill data and requests raised while busy being ignored.

// File: rtl/pac_pkg.sv
package pac_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROBE = 2'd1,
    ST_FILL  = 2'd2
  } pac_state_e;
endpackage

// File: rtl/pac_array.sv
module pac_array #(
  parameter int LINES  = 16,
  parameter int TAG_W  = 14,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  logic [LINES-1:0]  vld_q, vld_d;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  always_comb begin
    vld_d = vld_q;
    if (wr_en) vld_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign rd_valid = vld_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = data_q[rd_idx];

  // R5: a written slot must read back as valid afterwards
  p_write_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_idx)]);
endmodule

// File: rtl/pac_ctrl.sv
module pac_ctrl
  import pac_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WAYS   = 4,
  parameter int SETS   = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int IDX_W = SET_W + WAY_W,
  localparam int TAG_W = ADDR_W - SET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic [WAY_W:0]    rsp_probes,
  output logic              fill_req_valid,
  output logic [ADDR_W-1:0] fill_req_addr,
  input  logic              fill_rsp_valid,
  input  logic [DATA_W-1:0] fill_rsp_data,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_valid,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [DATA_W-1:0] wr_data
);
  pac_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [WAY_W-1:0]  way_q, way_d;
  logic              vic_found_q, vic_found_d;
  logic [WAY_W-1:0]  vic_way_q, vic_way_d;
  logic              rsp_valid_q, rsp_valid_d;
  logic              rsp_hit_q, rsp_hit_d;
  logic [WAY_W-1:0]  rsp_way_q, rsp_way_d;
  logic [WAY_W:0]    rsp_probes_q, rsp_probes_d;
  logic [DATA_W-1:0] rsp_data_q, rsp_data_d;
  logic              rsp_load;

  logic [SET_W-1:0]  set_idx;
  logic [TAG_W-1:0]  cur_tag;
  logic              probe_hit;
  logic              last_way;

  assign set_idx   = addr_q[SET_W-1:0];
  assign cur_tag   = addr_q[ADDR_W-1:SET_W];
  assign rd_idx    = {way_q, set_idx};
  assign probe_hit = (state_q == ST_PROBE) && rd_valid && (rd_tag == cur_tag);
  assign last_way  = (way_q == WAY_W'(WAYS - 1));

  always_comb begin
    state_d      = state_q;
    addr_d       = addr_q;
    way_d        = way_q;
    vic_found_d  = vic_found_q;
    vic_way_d    = vic_way_q;
    rsp_valid_d  = 1'b0;
    rsp_hit_d    = rsp_hit_q;
    rsp_way_d    = rsp_way_q;
    rsp_probes_d = rsp_probes_q;
    rsp_data_d   = rsp_data_q;
    rsp_load     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          addr_d      = req_addr;
          way_d       = '0;
          vic_found_d = 1'b0;
          vic_way_d   = '0;
          state_d     = ST_PROBE;
        end
      end
      ST_PROBE: begin
        if (probe_hit) begin
          rsp_valid_d  = 1'b1;
          rsp_load     = 1'b1;
          rsp_data_d   = rd_data;
          rsp_hit_d    = 1'b1;
          rsp_way_d    = way_q;
          rsp_probes_d = {1'b0, way_q} + 1'b1;
          state_d      = ST_IDLE;
        end else begin
          if (!rd_valid && !vic_found_q) begin
            vic_found_d = 1'b1;
            vic_way_d   = way_q;
          end
          if (last_way) state_d = ST_FILL;
          else          way_d   = way_q + 1'b1;
        end
      end
      ST_FILL: begin
        if (fill_rsp_valid) begin
          rsp_valid_d  = 1'b1;
          rsp_load     = 1'b1;
          rsp_data_d   = fill_rsp_data;
          rsp_hit_d    = 1'b0;
          rsp_way_d    = vic_way_q;
          rsp_probes_d = (WAY_W+1)'(WAYS);
          state_d      = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      way_q        <= '0;
      vic_found_q  <= 1'b0;
      vic_way_q    <= '0;
      rsp_valid_q  <= 1'b0;
      rsp_hit_q    <= 1'b0;
      rsp_way_q    <= '0;
      rsp_probes_q <= '0;
    end else begin
      state_q      <= state_d;
      way_q        <= way_d;
      vic_found_q  <= vic_found_d;
      vic_way_q    <= vic_way_d;
      rsp_valid_q  <= rsp_valid_d;
      rsp_hit_q    <= rsp_hit_d;
      rsp_way_q    <= rsp_way_d;
      rsp_probes_q <= rsp_probes_d;
    end
  end

  always_ff @(posedge clk) begin
    if (state_q == ST_IDLE) addr_q <= addr_d;
    if (rsp_load)           rsp_data_q <= rsp_data_d;
  end

  assign req_ready      = (state_q == ST_IDLE);
  assign fill_req_valid = (state_q == ST_FILL);
  assign fill_req_addr  = addr_q;
  assign wr_en          = (state_q == ST_FILL) && fill_rsp_valid;
  assign wr_idx         = {vic_way_q, set_idx};
  assign wr_tag         = cur_tag;
  assign wr_data        = fill_rsp_data;
  assign rsp_valid      = rsp_valid_q;
  assign rsp_data       = rsp_data_q;
  assign rsp_hit        = rsp_hit_q;
  assign rsp_way        = rsp_way_q;
  assign rsp_probes     = rsp_probes_q;

  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_hit_probes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (rsp_probes == ({1'b0, rsp_way} + 1'b1)));
  p_fill_probes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_probes == (WAY_W+1)'(WAYS)));
  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_fill_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid && !fill_rsp_valid) |=> (fill_req_valid && $stable(fill_req_addr)));
endmodule

// File: rtl/pseudo_assoc_cache.sv
module pseudo_assoc_cache #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WAYS   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [ADDR_W-1:0]        req_addr,
  output logic                     req_ready,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_data,
  output logic                     rsp_hit,
  output logic [$clog2(WAYS)-1:0]  rsp_way,
  output logic [$clog2(WAYS):0]    rsp_probes,
  output logic                     fill_req_valid,
  output logic [ADDR_W-1:0]        fill_req_addr,
  input  logic                     fill_rsp_valid,
  input  logic [DATA_W-1:0]        fill_rsp_data
);
  localparam int SETS  = LINES / WAYS;
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int IDX_W = SET_W + WAY_W;
  localparam int TAG_W = ADDR_W - SET_W;

  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic              rd_valid, wr_en;
  logic [TAG_W-1:0]  rd_tag, wr_tag;
  logic [DATA_W-1:0] rd_data, wr_data;

  pac_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAYS(WAYS), .SETS(SETS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_hit(rsp_hit),
    .rsp_way(rsp_way), .rsp_probes(rsp_probes),
    .fill_req_valid(fill_req_valid), .fill_req_addr(fill_req_addr),
    .fill_rsp_valid(fill_rsp_valid), .fill_rsp_data(fill_rsp_data),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data)
  );

  pac_array #(
    .LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_array (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data)
  );
endmodule

// File: tb/pseudo_assoc_cache_tb.sv
module pseudo_assoc_cache_tb;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int LINES  = 16;
  localparam int WAYS   = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_ready;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_data;
  logic              rsp_hit;
  logic [1:0]        rsp_way;
  logic [2:0]        rsp_probes;
  logic              fill_req_valid;
  logic [ADDR_W-1:0] fill_req_addr;
  logic              fill_rsp_valid = 1'b0;
  logic [DATA_W-1:0] fill_rsp_data = '0;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  pseudo_assoc_cache #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WAYS(WAYS)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_hit(rsp_hit),
    .rsp_way(rsp_way), .rsp_probes(rsp_probes),
    .fill_req_valid(fill_req_valid), .fill_req_addr(fill_req_addr),
    .fill_rsp_valid(fill_rsp_valid), .fill_rsp_data(fill_rsp_data)
  );

  // vector: {addr[15:0], hit, way[1:0], probes[2:0]}
  localparam int NV = 14;
  localparam logic [21:0] VEC [NV] = '{
    {16'h0010, 1'b0, 2'd0, 3'd4},  // R1 R5 cold miss, way 0
    {16'h0010, 1'b1, 2'd0, 3'd1},  // R3 hit probe 0
    {16'h0020, 1'b0, 2'd1, 3'd4},  // R5 first invalid = way 1
    {16'h0030, 1'b0, 2'd2, 3'd4},
    {16'h0040, 1'b0, 2'd3, 3'd4},
    {16'h0040, 1'b1, 2'd3, 3'd4},  // R2 R3 hit on last probe
    {16'h0030, 1'b1, 2'd2, 3'd3},
    {16'h0050, 1'b0, 2'd0, 3'd4},  // R5 full set -> way 0
    {16'h0010, 1'b0, 2'd0, 3'd4},  // evicted, refilled into way 0
    {16'h0020, 1'b1, 2'd1, 3'd2},
    {16'h0011, 1'b0, 2'd0, 3'd4},  // set 1
    {16'h4011, 1'b0, 2'd1, 3'd4},  // R8 same set, upper bit differs
    {16'h0011, 1'b1, 2'd0, 3'd1},  // R8
    {16'h4011, 1'b1, 2'd1, 3'd2}   // R8
  };

  function automatic logic [DATA_W-1:0] fdata(input logic [ADDR_W-1:0] a);
    return {~a, a};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Issues one request; optionally holds a second request on the port while busy.
  task automatic run_req(input logic [ADDR_W-1:0] a, input bit e_hit,
                         input logic [1:0] e_way, input logic [2:0] e_probes,
                         input bit stray);
    int lat;
    int rsp_cnt;
    bit done;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = stray;
    if (stray) req_addr = a ^ 16'h0101;
    lat = 0; rsp_cnt = 0; done = 1'b0;
    while (!done && lat < 40) begin
      if (stray && !rsp_valid)
        chk(req_ready == 1'b0, "R7", "ready while busy", req_ready, 0);
      if (fill_req_valid) begin
        chk(lat == WAYS, "R4", "refill latency", lat, WAYS);
        chk(fill_req_addr == a, "R4", "refill addr", fill_req_addr, a);
        fill_rsp_valid = 1'b1;
        fill_rsp_data  = fdata(a);
        @(negedge clk);
        fill_rsp_valid = 1'b0;
        lat++;
      end
      if (rsp_valid) begin
        req_valid = 1'b0;
        rsp_cnt++;
        done = 1'b1;
        chk(lat == (e_hit ? int'(e_way) + 1 : WAYS + 1), "R3", "response latency",
            lat, e_hit ? int'(e_way) + 1 : WAYS + 1);
        chk(rsp_hit == e_hit, "R6", "hit flag", rsp_hit, e_hit);
        chk(rsp_way == e_way, "R5", "way", rsp_way, e_way);
        chk(rsp_probes == e_probes, "R2", "probe count", rsp_probes, e_probes);
        chk(rsp_data == fdata(a), "R8", "data", rsp_data, fdata(a));
      end else begin
        @(negedge clk);
        lat++;
      end
    end
    chk(done, "R3", "response seen", done, 1);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10", "pulse width", rsp_valid, 0);
    if (stray) begin
      chk(rsp_cnt == 1, "R7", "responses for held request", rsp_cnt, 1);
      chk(fill_req_valid == 1'b0 && req_ready == 1'b1, "R7", "no second request",
          {fill_req_valid, req_ready}, 2'b01);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1", "rsp after reset", rsp_valid, 0);
    chk(fill_req_valid == 1'b0, "R1", "fill after reset", fill_req_valid, 0);

    for (int i = 0; i < NV; i++)
      run_req(VEC[i][21:6], VEC[i][5], VEC[i][4:3], VEC[i][2:0], 1'b0);

    // R7: request held on the port while a miss is serviced
    run_req(16'h0022, 1'b0, 2'd0, 3'd4, 1'b1);

    // R9: stray refill data while idle must not disturb a stored line
    @(negedge clk);
    fill_rsp_valid = 1'b1;
    fill_rsp_data  = 32'hDEAD_BEEF;
    repeat (2) @(negedge clk);
    fill_rsp_valid = 1'b0;
    chk(rsp_valid == 1'b0, "R9", "no response to stray fill", rsp_valid, 0);
    run_req(16'h0011, 1'b1, 2'd0, 3'd1, 1'b0);
    run_req(16'h0022, 1'b1, 2'd0, 3'd1, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule